// File: doc/BRIEF.md
# Hardware Pointer Sprite Overlay

This block lays one 16 by 16 pointer image over a stream of 16-bit 5-6-5 pixels from a raster. Each sprite pixel is a 4-bit code: one bit says whether the pixel covers the background, and three bits turn red, green and blue fully on or off. A visible pixel that falls inside the sprite window and is marked opaque is replaced by the saturated colour. Every other pixel passes through unchanged. The pixel path has no registers, so the output beat belongs to the same cycle as the input beat.

The image is not held on chip as a whole. When the horizontal blanking flag rises, the block checks whether the next line to be shown crosses the window. If it does, the block reads that line's 64 bits as four 16-bit words over a word-read port and stores them in a one-row buffer. It reads only while blanking is high. Software places the sprite and points at its image through three writable registers. Those values go into shadow copies, and the copies move into the working set when vertical blanking rises, so a move never tears a frame.

Back-pressure on the pixel stream passes straight through: `s_ready` equals `m_ready`, `m_valid` equals `s_valid`, and a beat moves when valid and ready are both high on a clock edge. On the read-request side, `dma_req_valid` stays high with a steady address until `dma_req_ready` is seen. Read responses carry no ready signal and must come back in request order before blanking ends.

Top module: `ptr_sprite`

## Requirements
- R1: When a pixel takes sprite colour, code bit 2 sets bits [15:11] to 5'h1F, bit 1 sets bits [10:5] to 6'h3F and bit 0 sets bits [4:0] to 5'h1F. A channel whose bit is clear becomes zero. Code bit 3 set marks the pixel opaque.
- R2: A sprite code with bit 3 clear is transparent, and `m_data` equals `s_data` for that pixel.
- R3: Screen column X+c (c from 0 to 15) of sprite row r takes code bits [15-4*(c%4) -: 4] of word c/4. Word k of row r is read from word address base + 4*r + k, and the four words are requested in order k = 0..3.
- R4: A row read starts only on the rising edge of `hblank`, and only when `next_y` lies in [Y, Y+15]. Exactly four requests are issued for a hit and none for a miss. `dma_req_valid` is never high while `hblank` is low.
- R5: While `dma_req_valid` is high and `dma_req_ready` is low during blanking, the next cycle still shows the request with the same address.
- R6: If `hblank` falls before all four words have arrived, the read is dropped, and that line shows no sprite pixels.
- R7: Register writes (`cfg_sel` 0 = X, 1 = Y, 2 = word base address) take effect only at the next rising edge of `vblank`. Until then the working position and base stay unchanged.
- R8: The window is X..X+15 by Y..Y+15, computed without wrap-around. A sprite near the top of the coordinate range is clipped and never shows up at column 0 or line 0.
- R9: A pixel with `s_active` low, or outside the window, or on a line whose row was not read, leaves the block unchanged.
- R10: `m_valid` follows `s_valid` and `s_ready` follows `m_ready` in the same cycle, with zero latency.
- R11: After reset the registers read as zero, no row is held, no request is pending, and pixels pass unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 X, 1 Y, 2 base |
| cfg_wdata | input | 24 | Register write data |
| vblank | input | 1 | Vertical blanking level |
| hblank | input | 1 | Horizontal blanking level |
| next_y | input | 10 | Line that follows the current blanking gap |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Input pixel ready |
| s_active | input | 1 | Pixel is in the visible area |
| s_x | input | 10 | Pixel column |
| s_y | input | 10 | Pixel line |
| s_data | input | 16 | Background 5-6-5 colour |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Output pixel ready |
| m_data | output | 16 | Mixed 5-6-5 colour |
| dma_req_valid | output | 1 | Word read request valid |
| dma_req_ready | input | 1 | Word read request accepted |
| dma_req_addr | output | 24 | Word address of the request |
| dma_rsp_valid | input | 1 | Read response valid |
| dma_rsp_data | input | 16 | Read response word |

## Verification
Some properties are checked on every cycle. Requests appear only in blanking, and a stalled request holds its address. A row only becomes usable while blanking is high. The working registers move only on the vertical-blank edge. Any pixel that differs from its background carries saturated or zero channels. Other behaviour needs the bench's scenarios. These cover the nibble order across the four words, the request addresses, transparency against random backgrounds, the dropped read on a short gap, a position write that stays invisible until the frame edge, and clipping near the top of the coordinate range.

// File: rtl/sprite_pkg.sv
package sprite_pkg;

  typedef enum logic [1:0] {
    F_IDLE = 2'd0,
    F_REQ  = 2'd1,
    F_WAIT = 2'd2
  } fetch_state_t;

  localparam int unsigned RGB_W = 16;

  // Saturating expansion of a 3-bit on/off colour into 5-6-5
  function automatic logic [RGB_W-1:0] expand_rgb(input logic [2:0] rgb);
    return {{5{rgb[2]}}, {6{rgb[1]}}, {5{rgb[0]}}};
  endfunction

endpackage

// File: rtl/sprite_regs.sv
module sprite_regs #(
  parameter int X_W    = 10,
  parameter int Y_W    = 10,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              vblank,
  output logic [X_W-1:0]    live_x,
  output logic [Y_W-1:0]    live_y,
  output logic [ADDR_W-1:0] live_base
);

  logic [X_W-1:0]    sh_x;
  logic [Y_W-1:0]    sh_y;
  logic [ADDR_W-1:0] sh_base;
  logic              vb_q;
  logic              frame_tick;

  assign frame_tick = vblank && !vb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_x      <= '0;
      sh_y      <= '0;
      sh_base   <= '0;
      live_x    <= '0;
      live_y    <= '0;
      live_base <= '0;
      vb_q      <= 1'b0;
    end else begin
      vb_q <= vblank;
      if (cfg_we) begin
        unique case (cfg_sel)
          2'd0:    sh_x    <= cfg_wdata[X_W-1:0];
          2'd1:    sh_y    <= cfg_wdata[Y_W-1:0];
          2'd2:    sh_base <= cfg_wdata;
          default: ;
        endcase
      end
      if (frame_tick) begin
        live_x    <= sh_x;
        live_y    <= sh_y;
        live_base <= sh_base;
      end
    end
  end

  // Working registers only move on the frame edge
  assert_live_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(live_x) && $stable(live_y) && $stable(live_base));

endmodule

// File: rtl/sprite_fetch.sv
module sprite_fetch
  import sprite_pkg::*;
#(
  parameter int Y_W    = 10,
  parameter int ADDR_W = 24,
  parameter int SIZE   = 16,
  parameter int BPP    = 4,
  parameter int WORD_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hblank,
  input  logic [Y_W-1:0]         next_y,
  input  logic [Y_W-1:0]         live_y,
  input  logic [ADDR_W-1:0]      live_base,
  output logic                   dma_req_valid,
  input  logic                   dma_req_ready,
  output logic [ADDR_W-1:0]      dma_req_addr,
  input  logic                   dma_rsp_valid,
  input  logic [WORD_W-1:0]      dma_rsp_data,
  output logic [SIZE*BPP-1:0]    row_bits,
  output logic                   row_valid,
  output logic [Y_W-1:0]         row_y
);

  localparam int ROW_BITS = SIZE * BPP;
  localparam int WORDS    = ROW_BITS / WORD_W;
  localparam int WCNT_W   = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int ROW_W    = $clog2(SIZE);

  fetch_state_t      state;
  logic              hb_q;
  logic              hb_rise;
  logic [Y_W:0]      dy;
  logic              hit;
  logic [ROW_W-1:0]  row_idx;
  logic [WCNT_W-1:0] req_cnt;
  logic [WCNT_W-1:0] rsp_cnt;
  logic              req_last;
  logic              rsp_last;
  logic [WORD_W-1:0] words [WORDS];

  assign hb_rise  = hblank && !hb_q;
  assign dy       = {1'b0, next_y} - {1'b0, live_y};
  assign hit      = (next_y >= live_y) && (dy < (Y_W+1)'(SIZE));
  assign req_last = (req_cnt == WCNT_W'(WORDS-1));
  assign rsp_last = (rsp_cnt == WCNT_W'(WORDS-1));

  assign dma_req_valid = (state == F_REQ) && hblank;
  assign dma_req_addr  = live_base + ADDR_W'({row_idx, req_cnt});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= F_IDLE;
      hb_q      <= 1'b0;
      row_valid <= 1'b0;
      row_y     <= '0;
      row_idx   <= '0;
      req_cnt   <= '0;
      rsp_cnt   <= '0;
    end else begin
      hb_q <= hblank;
      if (state == F_IDLE) begin
        if (hb_rise) begin
          row_valid <= 1'b0;
          if (hit) begin
            state   <= F_REQ;
            row_idx <= dy[ROW_W-1:0];
            row_y   <= next_y;
            req_cnt <= '0;
            rsp_cnt <= '0;
          end
        end
      end else if (!hblank) begin
        state <= F_IDLE;
      end else begin
        if (state == F_REQ && dma_req_ready) begin
          req_cnt <= req_cnt + 1'b1;
          if (req_last) state <= F_WAIT;
        end
        if (dma_rsp_valid) begin
          rsp_cnt <= rsp_cnt + 1'b1;
          if (rsp_last) begin
            row_valid <= 1'b1;
            state     <= F_IDLE;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (state != F_IDLE && hblank && dma_rsp_valid) words[rsp_cnt] <= dma_rsp_data;
  end

  // First word holds the leftmost pixels in the top of the row
  for (genvar k = 0; k < WORDS; k++) begin : g_row
    assign row_bits[ROW_BITS-1-k*WORD_W -: WORD_W] = words[k];
  end

  assert_req_in_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req_valid |-> hblank);

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req_valid && !dma_req_ready |=> !hblank || (dma_req_valid && $stable(dma_req_addr)));

  assert_row_in_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(row_valid) |-> $past(hblank) && $past(dma_rsp_valid));

endmodule

// File: rtl/sprite_mixer.sv
module sprite_mixer
  import sprite_pkg::*;
#(
  parameter int X_W  = 10,
  parameter int Y_W  = 10,
  parameter int SIZE = 16,
  parameter int BPP  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_active,
  input  logic [X_W-1:0]      s_x,
  input  logic [Y_W-1:0]      s_y,
  input  logic [RGB_W-1:0]    s_data,
  input  logic [X_W-1:0]      live_x,
  input  logic [SIZE*BPP-1:0] row_bits,
  input  logic                row_valid,
  input  logic [Y_W-1:0]      row_y,
  output logic [RGB_W-1:0]    m_data
);

  localparam int ROW_BITS = SIZE * BPP;
  localparam int COL_W    = $clog2(SIZE);

  logic [X_W:0]        dx;
  logic                in_x;
  logic                in_y;
  logic [COL_W-1:0]    col;
  logic [ROW_BITS-1:0] shifted;
  logic [BPP-1:0]      code;

  assign dx      = {1'b0, s_x} - {1'b0, live_x};
  assign in_x    = (s_x >= live_x) && (dx < (X_W+1)'(SIZE));
  assign in_y    = row_valid && (row_y == s_y);
  assign col     = dx[COL_W-1:0];
  assign shifted = row_bits << (col * BPP);
  assign code    = shifted[ROW_BITS-1 -: BPP];

  always_comb begin
    m_data = s_data;
    if (s_active && in_x && in_y && code[BPP-1]) m_data = expand_rgb(code[2:0]);
  end

  assert_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_active || !row_valid || s_y != row_y) |-> m_data == s_data);

  assert_saturate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (m_data != s_data) |-> ((m_data[15:11] == 5'h00 || m_data[15:11] == 5'h1F) &&
                            (m_data[10:5]  == 6'h00 || m_data[10:5]  == 6'h3F) &&
                            (m_data[4:0]   == 5'h00 || m_data[4:0]   == 5'h1F)));

endmodule

// File: rtl/ptr_sprite.sv
module ptr_sprite
  import sprite_pkg::*;
#(
  parameter int X_W    = 10,
  parameter int Y_W    = 10,
  parameter int ADDR_W = 24,
  parameter int SIZE   = 16,
  parameter int BPP    = 4,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              vblank,
  input  logic              hblank,
  input  logic [Y_W-1:0]    next_y,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic              s_active,
  input  logic [X_W-1:0]    s_x,
  input  logic [Y_W-1:0]    s_y,
  input  logic [RGB_W-1:0]  s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [RGB_W-1:0]  m_data,
  output logic              dma_req_valid,
  input  logic              dma_req_ready,
  output logic [ADDR_W-1:0] dma_req_addr,
  input  logic              dma_rsp_valid,
  input  logic [WORD_W-1:0] dma_rsp_data
);

  localparam int ROW_BITS = SIZE * BPP;

  logic [X_W-1:0]      live_x;
  logic [Y_W-1:0]      live_y;
  logic [ADDR_W-1:0]   live_base;
  logic [ROW_BITS-1:0] row_bits;
  logic                row_valid;
  logic [Y_W-1:0]      row_y;

  assign m_valid = s_valid;
  assign s_ready = m_ready;

  sprite_regs #(.X_W(X_W), .Y_W(Y_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .vblank(vblank), .live_x(live_x), .live_y(live_y), .live_base(live_base)
  );

  sprite_fetch #(.Y_W(Y_W), .ADDR_W(ADDR_W), .SIZE(SIZE), .BPP(BPP), .WORD_W(WORD_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .hblank(hblank), .next_y(next_y), .live_y(live_y),
    .live_base(live_base), .dma_req_valid(dma_req_valid), .dma_req_ready(dma_req_ready),
    .dma_req_addr(dma_req_addr), .dma_rsp_valid(dma_rsp_valid), .dma_rsp_data(dma_rsp_data),
    .row_bits(row_bits), .row_valid(row_valid), .row_y(row_y)
  );

  sprite_mixer #(.X_W(X_W), .Y_W(Y_W), .SIZE(SIZE), .BPP(BPP)) u_mixer (
    .clk(clk), .rst_n(rst_n), .s_active(s_active), .s_x(s_x), .s_y(s_y), .s_data(s_data),
    .live_x(live_x), .row_bits(row_bits), .row_valid(row_valid), .row_y(row_y), .m_data(m_data)
  );

endmodule

// File: tb/ptr_sprite_bench.sv
`timescale 1ns/1ps
module ptr_sprite_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [23:0] cfg_wdata = '0;
  logic        vblank = 1'b0, hblank = 1'b0;
  logic [9:0]  next_y = '0;
  logic        s_valid = 1'b0, s_active = 1'b0, m_ready = 1'b1;
  logic [9:0]  s_x = '0, s_y = '0;
  logic [15:0] s_data = '0;
  logic        s_ready, m_valid, dma_req_valid;
  logic [15:0] m_data;
  logic [23:0] dma_req_addr;
  logic        dma_req_ready = 1'b0;
  logic        dma_rsp_valid = 1'b0;
  logic [15:0] dma_rsp_data = '0;

  int checks = 0, fails = 0, cycles = 0;
  int hs_total = 0, gap_violations = 0, hold_violations = 0;
  logic [23:0] hs_addr [4];
  logic        force_ready = 1'b0;
  logic        pend_q = 1'b0;
  logic [23:0] pend_addr = '0;

  // bench model of the working state
  int mx = 0, my = 0, mbase = 0, sx = 0, sy = 0, sbase = 0;
  bit row_ok = 0;
  int row_y = 0;

  always #2.5 clk = ~clk;

  ptr_sprite u_ptr_sprite (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .vblank(vblank), .hblank(hblank), .next_y(next_y), .s_valid(s_valid), .s_ready(s_ready),
    .s_active(s_active), .s_x(s_x), .s_y(s_y), .s_data(s_data), .m_valid(m_valid),
    .m_ready(m_ready), .m_data(m_data), .dma_req_valid(dma_req_valid),
    .dma_req_ready(dma_req_ready), .dma_req_addr(dma_req_addr),
    .dma_rsp_valid(dma_rsp_valid), .dma_rsp_data(dma_rsp_data)
  );

  function automatic logic [15:0] mem_word(input logic [23:0] a);
    logic [23:0] h;
    h = (a * 24'd40503) ^ (a >> 7) ^ 24'h00C3A5;
    return h[15:0];
  endfunction

  task automatic report(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: random ready, in-order response one cycle after acceptance
  always @(negedge clk) dma_req_ready = force_ready ? 1'b1 : (($urandom % 4) != 0);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    dma_rsp_valid <= dma_req_valid && dma_req_ready;
    dma_rsp_data  <= mem_word(dma_req_addr);
    if (dma_req_valid && dma_req_ready) begin
      hs_addr[hs_total % 4] <= dma_req_addr;
      hs_total <= hs_total + 1;
    end
    if (dma_req_valid && !hblank) gap_violations <= gap_violations + 1;
    if (pend_q && hblank && (!dma_req_valid || dma_req_addr != pend_addr))
      hold_violations <= hold_violations + 1;
    pend_q    <= dma_req_valid && !dma_req_ready;
    pend_addr <= dma_req_addr;
  end

  task automatic finish_run();
    report(gap_violations == 0, "R4 request outside blanking", gap_violations, 0);
    report(hold_violations == 0, "R5 request not held", hold_violations, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = 24'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      2'd0: sx = val;
      2'd1: sy = val;
      default: sbase = val;
    endcase
  endtask

  task automatic frame();
    @(negedge clk); vblank = 1'b1;
    repeat (2) @(negedge clk);
    vblank = 1'b0;
    mx = sx; my = sy; mbase = sbase;
  endtask

  // one blanking gap; checks request count and addresses
  task automatic gap(input int y, input int len, input bit full);
    int start;
    int expn;
    bit hit;
    @(negedge clk);
    start = hs_total;
    hblank = 1'b1; next_y = 10'(y);
    repeat (len) @(negedge clk);
    hblank = 1'b0;
    @(negedge clk);
    hit  = (y >= my) && (y - my < 16);
    expn = hit ? 4 : 0;
    if (full) begin
      report(hs_total - start == expn, "R4 request count", hs_total - start, expn);
      if (hit) begin
        for (int k = 0; k < 4; k++)
          report(hs_addr[(start + k) % 4] == 24'(mbase + (y - my) * 4 + k), "R3 word address",
                 hs_addr[(start + k) % 4], 24'(mbase + (y - my) * 4 + k));
      end
      row_ok = hit;
    end else begin
      row_ok = 0;
    end
    row_y = y;
  endtask

  function automatic logic [15:0] exp_pix(input int x, input int y, input bit act, input logic [15:0] bg,
                                          output string tag);
    int c;
    logic [15:0] w;
    logic [3:0] n;
    tag = "R9";
    if (!act || !row_ok || row_y != y || x < mx || x - mx >= 16) return bg;
    c = x - mx;
    w = mem_word(24'(mbase + (y - my) * 4 + c / 4));
    n = 4'((w >> (12 - 4 * (c % 4))) & 16'hF);
    if (!n[3]) begin tag = "R2"; return bg; end
    tag = "R1/R3";
    return {{5{n[2]}}, {6{n[1]}}, {5{n[0]}}};
  endfunction

  task automatic pix(input int x, input int y, input bit act, input string extra);
    logic [15:0] bg, e;
    string tag;
    bg = 16'($urandom);
    @(negedge clk);
    s_valid = 1'b1; s_active = act; s_x = 10'(x); s_y = 10'(y); s_data = bg;
    #1;
    e = exp_pix(x, y, act, bg, tag);
    report(m_data == e, {tag, " ", extra}, m_data, e);
  endtask

  initial begin
    int X, Y, ly;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    // R11 reset state
    #1;
    report(dma_req_valid == 1'b0, "R11 no request in reset", dma_req_valid, 0);
    rst_n = 1'b1;
    pix(0, 0, 1'b1, "R11 pass after reset");
    report(dma_req_valid == 1'b0, "R11 idle after reset", dma_req_valid, 0);
    gap(3, 40, 1'b1);      // registers at zero: line 3 is inside 0..15
    pix(2, 3, 1'b1, "R11 zero position");

    // R10 stream handshake
    @(negedge clk); m_ready = 1'b0; s_valid = 1'b1; #1;
    report(s_ready == 1'b0, "R10 ready follows", s_ready, 0);
    report(m_valid == 1'b1, "R10 valid follows", m_valid, 1);
    @(negedge clk); m_ready = 1'b1; s_valid = 1'b0; #1;
    report(s_ready == 1'b1 && m_valid == 1'b0, "R10 pass-through", {s_ready, m_valid}, 2'b10);

    // random scenarios
    for (int it = 0; it < 30; it++) begin
      X = $urandom % 640; Y = $urandom % 480;
      wr(2'd0, X); wr(2'd1, Y); wr(2'd2, $urandom % 24'h10000);
      frame();
      case ($urandom % 4)
        0: ly = Y + 16 + ($urandom % 8);
        1: ly = (Y > 0) ? Y - 1 : Y + 20;
        default: ly = Y + ($urandom % 16);
      endcase
      gap(ly, 40, 1'b1);
      for (int x = X - 4; x < X + 20; x++) if (x >= 0) pix(x, ly, 1'b1, "random");
      pix(X + 1, ly, 1'b0, "R9 blanked pixel");
      pix(X + 1, ly + 1, 1'b1, "R9 other line");
    end

    // R6 short gap drops the row
    wr(2'd0, 100); wr(2'd1, 200); wr(2'd2, 24'h1234); frame();
    force_ready = 1'b1;
    gap(205, 2, 1'b0);
    force_ready = 1'b0;
    for (int x = 100; x < 116; x++) pix(x, 205, 1'b1, "R6 aborted row");

    // R7 position write held until frame edge
    gap(205, 40, 1'b1);
    wr(2'd0, 300);
    for (int x = 100; x < 116; x++) pix(x, 205, 1'b1, "R7 old position");
    frame();
    for (int x = 296; x < 318; x++) pix(x, 205, 1'b1, "R7 new position");

    // R8 clipping, no wrap
    wr(2'd0, 1015); wr(2'd1, 1020); frame();
    gap(3, 40, 1'b1);
    report(row_ok == 0, "R8 no fetch across wrap", row_ok, 0);
    wr(2'd1, 470); frame();
    gap(475, 40, 1'b1);
    for (int x = 0; x < 4; x++) pix(x, 475, 1'b1, "R8 no wrap to column 0");
    for (int x = 1012; x < 1024; x++) pix(x, 475, 1'b1, "R8 clipped right");

    finish_run();
  end

endmodule